// File: doc/BRIEF.md
# Data-acquisition card register front end

This block sits between a 16-bit I/O bus and the converter side of a multifunction acquisition card. Sixteen byte addresses are decoded. A digital output latch, a read path for a 16-bit input port, a shared control register, a status word, an ADC trigger with a two-step byte read of the result, and a load path towards an eight-channel DAC all sit behind that decode. The converters themselves stay outside: the ADC is reached through a start pulse, a done pulse and a result bus, and the DAC through a channel, a data word and a load strobe.

Software starts a conversion by writing anything to the ADC address. It then polls the status word and reads the ADC address twice to collect the high byte and then the low byte. The raw 13-bit two's-complement sample is turned into offset binary before it is stored. The control register carries overlapping fields. The low three bits select the DAC channel. Bits 5:3 pick the ADC channel. The load field in bits 12:11 lets a write to the DAC address reach the converter. Two of its bits are held at 1 whatever software writes. A change of the selected input channel or of the enable bit starts a settling interval, and the status word reports when that interval has ended.

Top module: `daq_regif`

## Requirements
- R1: After reset, dout is 0x0000, ctrl_word is 0x0600, adc_start and dac_load are 0, and a status read returns 0x0008.
- R2: A write to address 0x0 loads dout from bus_wdata. A read of 0x0 returns din as it stood two clock edges earlier, through a two-stage synchronizer.
- R3: A write to 0x6 sets ctrl_word to bus_wdata with bits 15:13 cleared and bits 10:9 forced to 1. The value is visible after the write edge, and bits 10:9 are never 0 and bits 15:13 never 1.
- R4: A read of 0x6 returns the status word. Bit 3 is "settled", bit 4 is "conversion done", and every other bit is 0.
- R5: A control write that changes bits 6:3 clears status bit 3 for the following 4 clock edges, after which it reads 1. A control write that leaves bits 6:3 unchanged does not restart the interval.
- R6: A write to 0x4 raises adc_start for exactly the cycle after the write edge, and clears status bit 4.
- R7: An adc_done pulse sets status bit 4 and stores adc_result[12:0] with bit 12 inverted, zero-extended to 16 bits. adc_result bits 15:13 are ignored.
- R8: Successive reads of 0x4 return {8'h00, high byte}, then {8'h00, low byte}, then alternate. A write to 0x4 returns the order to the high byte.
- R9: When ctrl_word[12:11] is 2'b11, a write to 0x2 gives a one-cycle dac_load after the write edge, with dac_chan = ctrl_word[2:0] and dac_data = bus_wdata[11:0]. dac_chan and dac_data keep their values until the next load.
- R10: When ctrl_word[12:11] is not 2'b11, a write to 0x2 raises no dac_load and leaves dac_chan and dac_data unchanged.
- R11: Writes to any address other than 0x0, 0x2, 0x4 or 0x6 change neither dout nor ctrl_word. Reads of those addresses return 0, and bus_rdata is 0 in any cycle without a read, or with a read and a write together.
- R12: If a write to 0x4 and an adc_done pulse fall in the same cycle, the start takes priority. Status bit 4 stays 0 and the stored result is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address inside the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of bus_rd |
| din | input | 16 | Digital input pins |
| dout | output | 16 | Digital output latch |
| ctrl_word | output | 16 | Control register towards the converter front end |
| adc_start | output | 1 | One-cycle conversion start |
| adc_done | input | 1 | One-cycle end-of-conversion pulse |
| adc_result | input | 16 | Raw ADC sample, lower 13 bits significant |
| dac_load | output | 1 | One-cycle DAC load strobe |
| dac_chan | output | 3 | DAC channel for the load |
| dac_data | output | 12 | DAC code for the load |

## Verification
The case hardest to reach from the ports is a conversion start landing in the very cycle the converter reports done. The ordering of these two events decides both the status bit and the stored sample. The bench drives the write and the done pulse on the same clock edge. It then reads status and the result bytes to show that the stale sample survived and the flag stayed clear. A long random phase also mixes done pulses, ADC reads and start writes freely, under a behavioural model compared every clock. This brings out byte-pointer and settling-counter interactions that directed steps would not line up.

// File: rtl/daq_regif_pkg.sv
package daq_regif_pkg;

   // byte offsets inside the 16-byte window
   localparam logic [3:0] OFS_DIO      = 4'h0;
   localparam logic [3:0] OFS_DAC      = 4'h2;
   localparam logic [3:0] OFS_ADC      = 4'h4;
   localparam logic [3:0] OFS_CSR      = 4'h6;
   localparam logic [3:0] OFS_CLK      = 4'h8;
   localparam logic [3:0] OFS_ENC_DATA = 4'hC;
   localparam logic [3:0] OFS_ENC_CTRL = 4'hE;

   // control register layout
   localparam int CB_DAC_CH_LSB = 0;
   localparam int CB_ADC_CH_LSB = 3;
   localparam int CB_EN         = 6;
   localparam int CB_AZ         = 7;
   localparam int CB_CAL        = 8;
   localparam int CB_SH         = 9;
   localparam int CB_CLK        = 10;
   localparam int CB_LD_LSB     = 11;
   localparam int CB_LD_W       = 2;

   localparam logic [15:0] CTRL_MASK  = 16'h1FFF;
   localparam logic [15:0] CTRL_FORCE = (16'h1 << CB_SH) | (16'h1 << CB_CLK);

   // status layout
   localparam int SB_SETTLED = 3;
   localparam int SB_DONE    = 4;

   typedef enum logic {
      PTR_HI = 1'b0,
      PTR_LO = 1'b1
   } byte_sel_e;

   typedef struct packed {
      logic wr_dio;
      logic wr_dac;
      logic wr_adc;
      logic wr_csr;
      logic rd_adc;
   } strobe_t;

endpackage

// File: rtl/daq_din_sync.sv
module daq_din_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin : param_chk
      assert (W >= 1) else $error("daq_din_sync: W must be positive");
      assert (STAGES >= 0) else $error("daq_din_sync: STAGES must not be negative");
   end

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end

         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/daq_ctrl_reg.sv
module daq_ctrl_reg
   import daq_regif_pkg::*;
#(
   parameter int SETTLE_CYCLES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wdata,
   output logic [15:0] ctrl_q,
   output logic        settled
);

   initial begin : param_chk
      assert (SETTLE_CYCLES >= 0) else $error("daq_ctrl_reg: SETTLE_CYCLES must not be negative");
   end

   logic [15:0] next_w;
   assign next_w = (wdata & CTRL_MASK) | CTRL_FORCE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= CTRL_FORCE;
      else if (wr_en) ctrl_q <= next_w;
   end

   generate
      if (SETTLE_CYCLES == 0) begin : g_no_settle
         assign settled = 1'b1;
      end else begin : g_settle
         localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
         logic [CNT_W-1:0] cnt_q;
         logic             sel_chg;

         // input selection or enable moved: analog path needs time
         assign sel_chg = wr_en && (next_w[CB_EN:CB_ADC_CH_LSB] != ctrl_q[CB_EN:CB_ADC_CH_LSB]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (sel_chg)      cnt_q <= CNT_W'(SETTLE_CYCLES);
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end

         assign settled = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/daq_adc_if.sv
module daq_adc_if
   import daq_regif_pkg::*;
#(
   parameter int ADC_BITS   = 13,
   parameter bit OFFSET_BIN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_req,
   input  logic                rd_req,
   input  logic                adc_done,
   input  logic [ADC_BITS-1:0] adc_result,
   output logic                adc_start,
   output logic                conv_done,
   output logic [7:0]          rd_byte
);

   initial begin : param_chk
      assert (ADC_BITS >= 2 && ADC_BITS <= 16)
         else $error("daq_adc_if: ADC_BITS must lie in 2..16");
   end

   logic [ADC_BITS-1:0] conv_w;
   logic [15:0]         result_q;
   byte_sel_e           ptr_q;

   generate
      if (OFFSET_BIN) begin : g_offset
         assign conv_w = {~adc_result[ADC_BITS-1], adc_result[ADC_BITS-2:0]};
      end else begin : g_twos
         assign conv_w = adc_result;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adc_start <= 1'b0;
         conv_done <= 1'b0;
         result_q  <= '0;
         ptr_q     <= PTR_HI;
      end else begin
         adc_start <= start_req;
         if (start_req) begin
            conv_done <= 1'b0;
            ptr_q     <= PTR_HI;
         end else begin
            if (adc_done) begin
               conv_done <= 1'b1;
               result_q  <= 16'(conv_w);
            end
            if (rd_req) ptr_q <= (ptr_q == PTR_HI) ? PTR_LO : PTR_HI;
         end
      end
   end

   assign rd_byte = (ptr_q == PTR_HI) ? result_q[15:8] : result_q[7:0];

endmodule

// File: rtl/daq_dac_if.sv
module daq_dac_if #(
   parameter int DAC_BITS = 12,
   parameter int CH_W     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_req,
   input  logic                load_ok,
   input  logic [CH_W-1:0]     chan_in,
   input  logic [DAC_BITS-1:0] wdata,
   output logic                dac_load,
   output logic [CH_W-1:0]     dac_chan,
   output logic [DAC_BITS-1:0] dac_data
);

   initial begin : param_chk
      assert (DAC_BITS >= 1 && DAC_BITS <= 16) else $error("daq_dac_if: DAC_BITS must lie in 1..16");
      assert (CH_W >= 1 && CH_W <= 3) else $error("daq_dac_if: CH_W must lie in 1..3");
   end

   logic fire;
   assign fire = wr_req && load_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_load <= 1'b0;
         dac_chan <= '0;
         dac_data <= '0;
      end else begin
         dac_load <= fire;
         if (fire) begin
            dac_chan <= chan_in;
            dac_data <= wdata;
         end
      end
   end

endmodule

// File: rtl/daq_regif.sv
module daq_regif
   import daq_regif_pkg::*;
#(
   parameter int DAC_BITS       = 12,
   parameter int DAC_CH_W       = 3,
   parameter int ADC_BITS       = 13,
   parameter bit ADC_OFFSET_BIN = 1'b1,
   parameter int SETTLE_CYCLES  = 4,
   parameter int SYNC_STAGES    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [3:0]          bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [15:0]         bus_wdata,
   output logic [15:0]         bus_rdata,
   input  logic [15:0]         din,
   output logic [15:0]         dout,
   output logic [15:0]         ctrl_word,
   output logic                adc_start,
   input  logic                adc_done,
   input  logic [15:0]         adc_result,
   output logic                dac_load,
   output logic [DAC_CH_W-1:0] dac_chan,
   output logic [DAC_BITS-1:0] dac_data
);

   initial begin : param_chk
      assert (ADC_BITS >= 2 && ADC_BITS <= 16) else $error("daq_regif: ADC_BITS out of range");
      assert (DAC_BITS >= 1 && DAC_BITS <= 16) else $error("daq_regif: DAC_BITS out of range");
      assert (DAC_CH_W >= 1 && DAC_CH_W <= 3) else $error("daq_regif: DAC_CH_W must fit the channel field");
   end

   // ---------------- decode ----------------
   logic    rd_en;
   strobe_t stb;

   assign rd_en = bus_rd && !bus_wr;

   always_comb begin
      stb        = '0;
      stb.wr_dio = bus_wr && (bus_addr == OFS_DIO);
      stb.wr_dac = bus_wr && (bus_addr == OFS_DAC);
      stb.wr_adc = bus_wr && (bus_addr == OFS_ADC);
      stb.wr_csr = bus_wr && (bus_addr == OFS_CSR);
      stb.rd_adc = rd_en  && (bus_addr == OFS_ADC);
   end

   // ---------------- digital output latch ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dout <= '0;
      else if (stb.wr_dio) dout <= bus_wdata;
   end

   // ---------------- digital input ----------------
   logic [15:0] din_s;

   daq_din_sync #(.W(16), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (din),
      .q     (din_s)
   );

   // ---------------- control register ----------------
   logic [15:0] ctrl_q;
   logic        settled;

   daq_ctrl_reg #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (stb.wr_csr),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_q),
      .settled (settled)
   );

   assign ctrl_word = ctrl_q;

   // ---------------- ADC handshake ----------------
   logic       conv_done;
   logic [7:0] adc_byte;

   generate
      if (ADC_BITS < 16) begin : g_adc_pad
         logic adc_hi_unused;
         assign adc_hi_unused = ^adc_result[15:ADC_BITS];
      end
   endgenerate

   daq_adc_if #(.ADC_BITS(ADC_BITS), .OFFSET_BIN(ADC_OFFSET_BIN)) u_adc (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (stb.wr_adc),
      .rd_req     (stb.rd_adc),
      .adc_done   (adc_done),
      .adc_result (adc_result[ADC_BITS-1:0]),
      .adc_start  (adc_start),
      .conv_done  (conv_done),
      .rd_byte    (adc_byte)
   );

   // ---------------- DAC load path ----------------
   logic load_ok;
   assign load_ok = (ctrl_q[CB_LD_LSB +: CB_LD_W] == {CB_LD_W{1'b1}});

   daq_dac_if #(.DAC_BITS(DAC_BITS), .CH_W(DAC_CH_W)) u_dac (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (stb.wr_dac),
      .load_ok  (load_ok),
      .chan_in  (ctrl_q[CB_DAC_CH_LSB +: DAC_CH_W]),
      .wdata    (bus_wdata[DAC_BITS-1:0]),
      .dac_load (dac_load),
      .dac_chan (dac_chan),
      .dac_data (dac_data)
   );

   // ---------------- read mux ----------------
   logic [15:0] status_w;

   always_comb begin
      status_w             = '0;
      status_w[SB_SETTLED] = settled;
      status_w[SB_DONE]    = conv_done;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         unique case (bus_addr)
            OFS_DIO: bus_rdata = din_s;
            OFS_ADC: bus_rdata = {8'h00, adc_byte};
            OFS_CSR: bus_rdata = status_w;
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/daq_regif_chk.sv
module daq_regif_chk
   import daq_regif_pkg::*;
#(
   parameter int DAC_BITS = 12,
   parameter int DAC_CH_W = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [3:0]          bus_addr,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [15:0]         bus_rdata,
   input logic [15:0]         dout,
   input logic [15:0]         ctrl_word,
   input logic                adc_start,
   input logic                dac_load,
   input logic [DAC_CH_W-1:0] dac_chan,
   input logic [DAC_BITS-1:0] dac_data
);

   // R3
   ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[CB_CLK:CB_SH] == 2'b11) && (ctrl_word[15:13] == 3'b000));

   // R6
   start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> $past(bus_wr && (bus_addr == OFS_ADC)));

   // R6
   write_gives_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == OFS_ADC)) |=> adc_start);

   // R9
   load_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_load |-> $past(bus_wr && (bus_addr == OFS_DAC) && (ctrl_word[12:11] == 2'b11)));

   // R10
   dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_load |-> ($stable(dac_data) && $stable(dac_chan)));

   // R11
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == OFS_CLK || bus_addr == OFS_ENC_DATA || bus_addr == OFS_ENC_CTRL))
      |=> ($stable(dout) && $stable(ctrl_word)));

   // R11
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd || bus_wr) |-> (bus_rdata == 16'h0000));

endmodule

bind daq_regif daq_regif_chk #(.DAC_BITS(DAC_BITS), .DAC_CH_W(DAC_CH_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .dout      (dout),
   .ctrl_word (ctrl_word),
   .adc_start (adc_start),
   .dac_load  (dac_load),
   .dac_chan  (dac_chan),
   .dac_data  (dac_data)
);

// File: tb/daq_regif_tb.sv
module daq_regif_tb;

   localparam int SETTLE = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  bus_addr;
   logic        bus_wr, bus_rd;
   logic [15:0] bus_wdata, bus_rdata, din, dout, ctrl_word;
   logic        adc_start, adc_done;
   logic [15:0] adc_result;
   logic        dac_load;
   logic [2:0]  dac_chan;
   logic [11:0] dac_data;

   always #10 clk = ~clk;

   daq_regif u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .dout(dout),
      .ctrl_word(ctrl_word), .adc_start(adc_start), .adc_done(adc_done),
      .adc_result(adc_result), .dac_load(dac_load), .dac_chan(dac_chan), .dac_data(dac_data)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done_flag = 0;

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_dout, m_ctrl, m_res, m_din, m_ddata;
   logic [2:0]  m_dchan;
   int          m_settle;
   bit          m_done, m_ptr, m_dstart, m_dload;
   logic [15:0] hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dout = 0; m_ctrl = 16'h0600; m_res = 0; m_din = 0; m_ddata = 0; m_dchan = 0;
         m_settle = 0; m_done = 0; m_ptr = 0; m_dstart = 0; m_dload = 0;
         hist.delete();
      end else begin
         logic [15:0] nc;
         hist.push_back(din);
         if (hist.size() > 2) void'(hist.pop_front());
         m_din = (hist.size() == 2) ? hist[0] : 16'h0;

         m_dload = 0;
         if (bus_wr && bus_addr == 4'h2 && m_ctrl[12:11] == 2'b11) begin
            m_dload = 1; m_dchan = m_ctrl[2:0]; m_ddata = bus_wdata & 16'h0FFF;
         end

         if (bus_wr && bus_addr == 4'h6) begin
            nc = (bus_wdata & 16'h1FFF) | 16'h0600;
            if (nc[6:3] != m_ctrl[6:3]) m_settle = SETTLE;
            else if (m_settle > 0) m_settle--;
            m_ctrl = nc;
         end else if (m_settle > 0) m_settle--;

         if (bus_wr && bus_addr == 4'h0) m_dout = bus_wdata;

         m_dstart = bus_wr && bus_addr == 4'h4;
         if (m_dstart) begin
            m_done = 0; m_ptr = 0;
         end else begin
            if (adc_done) begin
               m_done = 1;
               m_res  = (adc_result & 16'h1FFF) ^ 16'h1000;
            end
            if (bus_rd && !bus_wr && bus_addr == 4'h4) m_ptr = ~m_ptr;
         end
      end
   end

   function automatic logic [15:0] m_rdata();
      if (!bus_rd || bus_wr) return 16'h0;
      case (bus_addr)
         4'h0: return m_din;
         4'h4: return m_ptr ? {8'h00, m_res[7:0]} : {8'h00, m_res[15:8]};
         4'h6: return (16'(m_settle == 0) << 3) | (16'(m_done) << 4);
         default: return 16'h0;
      endcase
   endfunction

   // compare every clock, halfway between falling and rising edges
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (rst_n === 1'b1) begin
            check("R2",  "model dout",      dout,      m_dout);
            check("R3",  "model ctrl_word", ctrl_word, m_ctrl);
            check("R6",  "model adc_start", adc_start, m_dstart);
            check("R9",  "model dac_load",  dac_load,  m_dload);
            check("R9",  "model dac_chan",  dac_chan,  m_dchan);
            check("R9",  "model dac_data",  dac_data,  m_ddata[11:0]);
            case (bus_addr)
               4'h0:    check("R2",  "model rdata", bus_rdata, m_rdata());
               4'h4:    check("R8",  "model rdata", bus_rdata, m_rdata());
               4'h6:    check("R4",  "model rdata", bus_rdata, m_rdata());
               default: check("R11", "model rdata", bus_rdata, m_rdata());
            endcase
         end
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic convert(input logic [15:0] v, input logic [7:0] hi, input logic [7:0] lo);
      logic [15:0] r;
      wr(4'h4, 16'h0000);
      check("R6", "adc_start after write", adc_start, 1'b1);
      rd(4'h6, r);
      check("R6", "done cleared by start", r, 16'h0008);
      @(negedge clk);
      adc_done = 1; adc_result = v;
      @(negedge clk);
      adc_done = 0;
      rd(4'h6, r);
      check("R7", "done set", r, 16'h0018);
      rd(4'h4, r);
      check("R8", "first byte high", r, {8'h00, hi});
      rd(4'h4, r);
      check("R7", "second byte low", r, {8'h00, lo});
      rd(4'h4, r);
      check("R8", "third read high again", r, {8'h00, hi});
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      report();
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [15:0] r;
      rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
      din = 0; adc_done = 0; adc_result = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1", "dout",      dout,      16'h0000);
      check("R1", "ctrl_word", ctrl_word, 16'h0600);
      check("R1", "adc_start", adc_start, 1'b0);
      check("R1", "dac_load",  dac_load,  1'b0);
      rd(4'h6, r);
      check("R1", "status", r, 16'h0008);

      // R2 digital ports
      din = 16'hA5C3;
      repeat (3) @(negedge clk);
      rd(4'h0, r);
      check("R2", "din read", r, 16'hA5C3);
      wr(4'h0, 16'h1234);
      check("R2", "dout write", dout, 16'h1234);

      // R3 control forcing
      wr(4'h6, 16'hFFFF);
      check("R3", "ctrl all ones", ctrl_word, 16'h1FFF);
      wr(4'h6, 16'h0000);
      check("R3", "ctrl zero", ctrl_word, 16'h0600);
      repeat (10) @(negedge clk);

      // R5 settling
      wr(4'h6, 16'h0628);
      rd(4'h6, r);
      check("R5", "settling after channel change", r, 16'h0000);
      rd(4'h6, r);
      check("R5", "still settling", r, 16'h0000);
      rd(4'h6, r);
      check("R5", "settled", r, 16'h0008);
      wr(4'h6, 16'h06A8);
      rd(4'h6, r);
      check("R5", "auto-zero change keeps settled", r, 16'h0008);

      // R7 / R8 conversions
      convert(16'h0FFF, 8'h1F, 8'hFF);
      convert(16'hFFFF, 8'h0F, 8'hFF);
      convert(16'hF000, 8'h00, 8'h00);
      convert(16'hE123, 8'h11, 8'h23);

      // R12 start and done in the same cycle
      @(negedge clk);
      bus_wr = 1; bus_addr = 4'h4; bus_wdata = 0; adc_done = 1; adc_result = 16'h0555;
      @(negedge clk);
      bus_wr = 0; adc_done = 0;
      rd(4'h6, r);
      check("R12", "done stays clear", r, 16'h0008);
      rd(4'h4, r);
      check("R12", "old result kept", r, 16'h0011);

      // R9 DAC load
      wr(4'h6, 16'h1805);
      check("R3", "ctrl with load field", ctrl_word, 16'h1E05);
      wr(4'h2, 16'hABCD);
      check("R9", "dac_load pulse", dac_load, 1'b1);
      check("R9", "dac_chan", dac_chan, 3'd5);
      check("R9", "dac_data", dac_data, 12'hBCD);
      @(negedge clk);
      check("R9", "dac_load one cycle", dac_load, 1'b0);

      // R10 load field not fully set
      wr(4'h6, 16'h0802);
      wr(4'h2, 16'h0123);
      check("R10", "no load field 01", dac_load, 1'b0);
      check("R10", "data kept field 01", dac_data, 12'hBCD);
      wr(4'h6, 16'h1002);
      wr(4'h2, 16'h0456);
      check("R10", "no load field 10", dac_load, 1'b0);
      check("R10", "chan kept field 10", dac_chan, 3'd5);

      // R11 unmapped addresses
      wr(4'h8, 16'hFFFF);
      wr(4'hC, 16'hFFFF);
      wr(4'hE, 16'hFFFF);
      check("R11", "dout unchanged", dout, 16'h1234);
      check("R11", "ctrl unchanged", ctrl_word, 16'h1602);
      rd(4'h8, r);
      check("R11", "read clock offset", r, 16'h0000);
      rd(4'hE, r);
      check("R11", "read encoder offset", r, 16'h0000);
      rd(4'h1, r);
      check("R11", "read odd offset", r, 16'h0000);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         bus_wr    = ($urandom % 4) == 0;
         bus_rd    = ($urandom % 3) != 0;
         case ($urandom % 8)
            0: bus_addr = 4'h0;
            1: bus_addr = 4'h2;
            2, 3: bus_addr = 4'h4;
            4, 5: bus_addr = 4'h6;
            6: bus_addr = 4'h8;
            default: bus_addr = 4'($urandom);
         endcase
         bus_wdata  = 16'($urandom);
         din        = 16'($urandom);
         adc_done   = ($urandom % 5) == 0;
         adc_result = 16'($urandom);
      end
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; adc_done = 0;
      repeat (4) @(negedge clk);
      report();
   end

endmodule